// File: doc/BRIEF.md
# Path Overhead Byte Insertion Selector

This block produces three path overhead bytes for the transmit side of a synchronous optical path: the path trace byte (J1), the signal label byte (C2) and the path status byte (G1). A one-cycle frame strobe marks each outgoing frame. On that strobe the block picks a new value for each byte, registers it, and holds it until the next strobe. The framer that builds the outgoing frame reads the three bytes from the block's outputs.

J1 can come from a 64-entry trace buffer that software loads through a write port. While trace sending is on, the block sends one entry per frame, in address order, and wraps at the end. When trace sending is off, J1 takes the pass-through value if that source is selected, or else a default byte. C2 uses a similar three-level choice: a programmed value, then the pass-through value, then the default. The default is all zeros or all ones, as set by one global control bit. The upper nibble of G1 carries the remote error count, which is the number of BIP-8 interleaved blocks found in error on the received signal. Software can replace that count with a programmed nibble, or force a fixed error code. The lower nibble of G1 passes through unchanged.

Top module: `poh_byte_sel`

## Requirements
- R1: While reset is asserted, and after its release until the first frame strobe, the J1, C2 and G1 outputs are 0x00. The trace index starts at entry 0.
- R2: Each output byte is registered on the clock edge where frame_strobe is high, and shows its new value after that edge. While no strobe arrives, the outputs hold their values, whatever the other inputs do, including writes to the trace buffer.
- R3: While trace_en is high, each strobe places the trace buffer entry at the current index into J1, and the index then advances by one. The index wraps from entry 63 to entry 0. The bytes are sent exactly as software wrote them through the write port; the block generates no checksum.
- R4: When trace_en goes from 0 to 1, the trace index returns to 0. The first strobe in or after that cycle sends entry 0, even if the index had stopped elsewhere.
- R5: While trace_en is low, J1 is j1_pass when j1_pass_sel is 1. Otherwise J1 is the default byte.
- R6: The default byte is 0x00 when dflt_ones is 0 and 0xFF when dflt_ones is 1. It applies to both J1 and C2.
- R7: C2 is c2_prog when c2_prog_en is 1. Otherwise C2 is c2_pass when c2_pass_sel is 1. Otherwise C2 is the default byte.
- R8: With neither override active, G1[7:4] is the received BIP error count. Counts above 8 are sent as 8.
- R9: When rei_inh is 1 and rei_force is 0, G1[7:4] is rei_prog.
- R10: When rei_force is 1, G1[7:4] is 0x3, whatever the states of rei_inh and the count.
- R11: G1[3:0] equals g1_low as sampled on the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse per outgoing frame |
| trace_en | input | 1 | Send the trace buffer in J1 |
| j1_pass_sel | input | 1 | Use the pass-through value for J1 when trace is off |
| j1_pass | input | 8 | Pass-through J1 value |
| c2_prog_en | input | 1 | Use the programmed C2 value |
| c2_prog | input | 8 | Programmed C2 value |
| c2_pass_sel | input | 1 | Use the pass-through C2 value |
| c2_pass | input | 8 | Pass-through C2 value |
| dflt_ones | input | 1 | Default byte is 0xFF when 1, 0x00 when 0 |
| tr_wr_en | input | 1 | Trace buffer write enable |
| tr_wr_addr | input | 6 | Trace buffer write address |
| tr_wr_data | input | 8 | Trace buffer write data |
| bip_err_cnt | input | 4 | Received BIP-8 error block count |
| rei_inh | input | 1 | Replace the count with rei_prog |
| rei_prog | input | 4 | Programmed G1 upper nibble |
| rei_force | input | 1 | Force the error code 0x3 into G1[7:4] |
| g1_low | input | 4 | G1 lower nibble, passed through |
| j1_byte | output | 8 | Outgoing J1 byte |
| c2_byte | output | 8 | Outgoing C2 byte |
| g1_byte | output | 8 | Outgoing G1 byte |

## Verification
The hardest cases to reach from the ports are the trace index wrap and the index reset on re-enable. The index is never visible directly; it shows only in which buffer entry appears in J1. The bench fills all 64 entries with distinct values and sends 66 frames, so the wrap shows as a repeat of entry 0 and then entry 1. It then turns trace off while the index rests at entry 2. It turns trace back on in the same cycle as a strobe, which must send entry 0 rather than entry 2.

// File: rtl/poh_pkg.sv
package poh_pkg;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int TRACE_LEN  = 64;
    localparam int TRACE_AW   = $clog2(TRACE_LEN);
    localparam logic [NIB_W-1:0] REI_FORCED = 4'h3;
    localparam logic [NIB_W-1:0] REI_MAX    = 4'd8;

    typedef struct packed {
        logic [BYTE_W-1:0] j1;
        logic [BYTE_W-1:0] c2;
        logic [BYTE_W-1:0] g1;
    } poh_bytes_t;

    typedef enum logic [1:0] {
        SRC_DEFAULT = 2'd0,
        SRC_PASS    = 2'd1,
        SRC_PROG    = 2'd2
    } byte_src_e;
endpackage

// File: rtl/poh_trace_buf.sv
module poh_trace_buf
    import poh_pkg::*;
#(
    parameter int DEPTH  = TRACE_LEN,
    parameter int DATA_W = BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      step,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          en_seen;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic          rise;
    logic [AW-1:0] cur;

    // Buffer storage: written by software, read at the frame step
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        seq_d         = seq_q;
        rise          = enable & ~seq_q.en_seen;
        cur           = rise ? '0 : seq_q.idx;
        seq_d.en_seen = enable;
        if (rise) seq_d.idx = '0;
        if (step && enable) seq_d.idx = (cur == LAST) ? '0 : cur + 1'b1;
    end

    assign rd_data = mem_q[cur];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/poh_byte_pick.sv
module poh_byte_pick
    import poh_pkg::*;
#(
    parameter int WIDTH = BYTE_W
) (
    input  logic             prog_en,
    input  logic [WIDTH-1:0] prog_val,
    input  logic             pass_sel,
    input  logic [WIDTH-1:0] pass_val,
    input  logic             dflt_ones,
    output logic [WIDTH-1:0] byte_out
);
    byte_src_e src;

    always_comb begin
        if (prog_en)       src = SRC_PROG;
        else if (pass_sel) src = SRC_PASS;
        else               src = SRC_DEFAULT;
        unique case (src)
            SRC_PROG: byte_out = prog_val;
            SRC_PASS: byte_out = pass_val;
            default:  byte_out = {WIDTH{dflt_ones}};
        endcase
    end
endmodule

// File: rtl/poh_g1_nib.sv
module poh_g1_nib
    import poh_pkg::*;
(
    input  logic [NIB_W-1:0] err_cnt,
    input  logic             inh,
    input  logic [NIB_W-1:0] prog_val,
    input  logic             force_err,
    output logic [NIB_W-1:0] nib_out
);
    logic [NIB_W-1:0] sat_cnt;

    always_comb begin
        sat_cnt = (err_cnt > REI_MAX) ? REI_MAX : err_cnt;
        if (force_err) nib_out = REI_FORCED;
        else if (inh)  nib_out = prog_val;
        else           nib_out = sat_cnt;
    end
endmodule

// File: rtl/poh_byte_sel.sv
module poh_byte_sel
    import poh_pkg::*;
#(
    parameter int TRACE_DEPTH = TRACE_LEN,
    localparam int TAW = $clog2(TRACE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              trace_en,
    input  logic              j1_pass_sel,
    input  logic [BYTE_W-1:0] j1_pass,
    input  logic              c2_prog_en,
    input  logic [BYTE_W-1:0] c2_prog,
    input  logic              c2_pass_sel,
    input  logic [BYTE_W-1:0] c2_pass,
    input  logic              dflt_ones,
    input  logic              tr_wr_en,
    input  logic [TAW-1:0]    tr_wr_addr,
    input  logic [BYTE_W-1:0] tr_wr_data,
    input  logic [NIB_W-1:0]  bip_err_cnt,
    input  logic              rei_inh,
    input  logic [NIB_W-1:0]  rei_prog,
    input  logic              rei_force,
    input  logic [NIB_W-1:0]  g1_low,
    output logic [BYTE_W-1:0] j1_byte,
    output logic [BYTE_W-1:0] c2_byte,
    output logic [BYTE_W-1:0] g1_byte
);
    poh_bytes_t out_d, out_q;
    logic [BYTE_W-1:0] trace_byte, j1_sel, c2_sel;
    logic [NIB_W-1:0]  rei_nib;

    poh_trace_buf #(.DEPTH(TRACE_DEPTH), .DATA_W(BYTE_W)) i_trace (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (trace_en),
        .step    (frame_strobe),
        .wr_en   (tr_wr_en),
        .wr_addr (tr_wr_addr),
        .wr_data (tr_wr_data),
        .rd_data (trace_byte)
    );

    // J1: trace buffer takes the programmed-value slot of the priority
    poh_byte_pick #(.WIDTH(BYTE_W)) i_j1_pick (
        .prog_en   (trace_en),
        .prog_val  (trace_byte),
        .pass_sel  (j1_pass_sel),
        .pass_val  (j1_pass),
        .dflt_ones (dflt_ones),
        .byte_out  (j1_sel)
    );

    poh_byte_pick #(.WIDTH(BYTE_W)) i_c2_pick (
        .prog_en   (c2_prog_en),
        .prog_val  (c2_prog),
        .pass_sel  (c2_pass_sel),
        .pass_val  (c2_pass),
        .dflt_ones (dflt_ones),
        .byte_out  (c2_sel)
    );

    poh_g1_nib i_g1 (
        .err_cnt   (bip_err_cnt),
        .inh       (rei_inh),
        .prog_val  (rei_prog),
        .force_err (rei_force),
        .nib_out   (rei_nib)
    );

    always_comb begin
        out_d = out_q;
        if (frame_strobe) begin
            out_d.j1 = j1_sel;
            out_d.c2 = c2_sel;
            out_d.g1 = {rei_nib, g1_low};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign j1_byte = out_q.j1;
    assign c2_byte = out_q.c2;
    assign g1_byte = out_q.g1;
endmodule

// File: rtl/poh_byte_sel_chk.sv
module poh_byte_sel_chk
    import poh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_strobe,
    input logic              trace_en,
    input logic              j1_pass_sel,
    input logic [BYTE_W-1:0] j1_pass,
    input logic              c2_prog_en,
    input logic [BYTE_W-1:0] c2_prog,
    input logic              c2_pass_sel,
    input logic              dflt_ones,
    input logic              rei_inh,
    input logic [NIB_W-1:0]  rei_prog,
    input logic              rei_force,
    input logic [NIB_W-1:0]  g1_low,
    input logic [BYTE_W-1:0] j1_byte,
    input logic [BYTE_W-1:0] c2_byte,
    input logic [BYTE_W-1:0] g1_byte
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> ($stable(j1_byte) && $stable(c2_byte) && $stable(g1_byte)));

    p_j1_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !trace_en && j1_pass_sel) |=> (j1_byte == $past(j1_pass)));

    p_j1_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !trace_en && !j1_pass_sel) |=>
            (j1_byte == {BYTE_W{$past(dflt_ones)}}));

    p_c2_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && c2_prog_en) |=> (c2_byte == $past(c2_prog)));

    p_c2_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !c2_prog_en && !c2_pass_sel) |=>
            (c2_byte == {BYTE_W{$past(dflt_ones)}}));

    p_rei_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !rei_force && !rei_inh) |=> (g1_byte[7:4] <= REI_MAX));

    p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !rei_force && rei_inh) |=> (g1_byte[7:4] == $past(rei_prog)));

    p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && rei_force) |=> (g1_byte[7:4] == REI_FORCED));

    p_low_nib_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> (g1_byte[3:0] == $past(g1_low)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r1: assert (j1_byte == '0 && c2_byte == '0 && g1_byte == '0);
        end
    end
endmodule

bind poh_byte_sel poh_byte_sel_chk i_chk (.*);

// File: tb/test_poh_byte_sel.sv
`timescale 1ns/1ps
module test_poh_byte_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b0;
    logic       trace_en = 1'b0;
    logic       j1_pass_sel = 1'b0;
    logic [7:0] j1_pass = 8'h5A;
    logic       c2_prog_en = 1'b0;
    logic [7:0] c2_prog = 8'hC7;
    logic       c2_pass_sel = 1'b0;
    logic [7:0] c2_pass = 8'h3C;
    logic       dflt_ones = 1'b0;
    logic       tr_wr_en = 1'b0;
    logic [5:0] tr_wr_addr = '0;
    logic [7:0] tr_wr_data = '0;
    logic [3:0] bip_err_cnt = '0;
    logic       rei_inh = 1'b0;
    logic [3:0] rei_prog = '0;
    logic       rei_force = 1'b0;
    logic [3:0] g1_low = '0;
    logic [7:0] j1_byte, c2_byte, g1_byte;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    poh_byte_sel i_poh_byte_sel (.*);

    // {j1_pass_sel,c2_prog_en,c2_pass_sel,dflt_ones,rei_inh,rei_force},
    // bip_err_cnt, rei_prog, g1_low, expected J1, C2, G1
    localparam int NV = 8;
    localparam logic [41:0] VEC [NV] = '{
        {6'b000000, 4'h0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00},
        {6'b000100, 4'h5, 4'h9, 4'hA, 8'hFF, 8'hFF, 8'h5A},
        {6'b101000, 4'h8, 4'h0, 4'h1, 8'h5A, 8'h3C, 8'h81},
        {6'b111100, 4'hF, 4'h0, 4'h2, 8'h5A, 8'hC7, 8'h82},
        {6'b010010, 4'h3, 4'hC, 4'h7, 8'h00, 8'hC7, 8'hC7},
        {6'b001111, 4'h7, 4'hC, 4'hF, 8'hFF, 8'h3C, 8'h3F},
        {6'b100101, 4'h2, 4'h0, 4'h0, 8'h5A, 8'hFF, 8'h30},
        {6'b000100, 4'h9, 4'h0, 4'h4, 8'hFF, 8'hFF, 8'h84}
    };

    function automatic logic [7:0] tr_pat(int i);
        return 8'((i * 37) + 11);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe for one cycle; outputs are sampled at the following falling edge
    task automatic frame();
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected run end", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 j1 in reset", j1_byte, 8'h00);
        check("R1 c2 in reset", c2_byte, 8'h00);
        check("R1 g1 in reset", g1_byte, 8'h00);
        rst_n = 1'b1;
        dflt_ones = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 j1 after reset", j1_byte, 8'h00);

        // Vector walk: R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {j1_pass_sel, c2_prog_en, c2_pass_sel, dflt_ones, rei_inh, rei_force,
             bip_err_cnt, rei_prog, g1_low} = VEC[i][41:24];
            frame();
            check($sformatf("R5/R6 j1 vec %0d", i), j1_byte, VEC[i][23:16]);
            check($sformatf("R7 c2 vec %0d", i), c2_byte, VEC[i][15:8]);
            check($sformatf("R8-R11 g1 vec %0d", i), g1_byte, VEC[i][7:0]);
        end

        // R2: no strobe, inputs and buffer writes change, outputs hold
        @(negedge clk);
        {j1_pass_sel, c2_prog_en, c2_pass_sel, dflt_ones, rei_inh, rei_force} = 6'b111011;
        bip_err_cnt = 4'h1; rei_prog = 4'h6; g1_low = 4'hE;
        tr_wr_en = 1'b1; tr_wr_addr = 6'd0; tr_wr_data = 8'h99;
        @(negedge clk) tr_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 j1 held", j1_byte, 8'hFF);
        check("R2 c2 held", c2_byte, 8'hFF);
        check("R2 g1 held", g1_byte, 8'h84);

        // R3: fill the trace buffer, then send it through a wrap
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            tr_wr_en = 1'b1; tr_wr_addr = 6'(a); tr_wr_data = tr_pat(a);
        end
        @(negedge clk) tr_wr_en = 1'b0;
        c2_prog_en = 1'b1; rei_force = 1'b0; rei_inh = 1'b0;
        trace_en = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 66; k++) begin
            frame();
            check($sformatf("R3 trace frame %0d", k), j1_byte, tr_pat(k % 64));
        end
        check("R7 c2 during trace", c2_byte, 8'hC7);

        // R5 with trace off, index left at entry 2
        @(negedge clk) trace_en = 1'b0;
        frame();
        check("R5 j1 pass after trace off", j1_byte, 8'h5A);

        // R4: re-enable in the same cycle as a strobe
        @(negedge clk);
        trace_en = 1'b1;
        frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
        check("R4 first entry after enable", j1_byte, tr_pat(0));
        frame();
        check("R4 second entry after enable", j1_byte, tr_pat(1));

        // R8: saturation once more at the top value
        @(negedge clk);
        rei_force = 1'b0; rei_inh = 1'b0; bip_err_cnt = 4'hF; g1_low = 4'h0;
        frame();
        check("R8 saturated count", g1_byte, 8'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule